// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is a two-channel peripheral input port. Each channel takes a byte from an external device under a strobe handshake, holds it in an input latch, and tells the host processor that data is waiting. The device pulls the channel's active-low strobe low with the byte on its data lines. The port then captures the byte and raises buffer-full. When the strobe returns high, the port can raise an interrupt request, but only if that channel's internal interrupt-enable bit is set. The host reads the channel over a small synchronous bus. The read start drops the interrupt request, and the read end clears buffer-full, which releases the device to send the next byte.

The interrupt-enable bits have no pins. The host sets or clears them with a single-bit set/reset command word on the same bus. The same command drives two spare general-purpose output lines. Both strobes pass through a synchronizer and an edge detector inside the single clock domain, and every output is registered.

Top module: `strobe_in_port`

## Requirements
- R1: After reset, both buffer-full outputs, both interrupt requests, both enable bits, `gp_out` and `rd_data` are 0.
- R2: A high-to-low strobe edge seen while the channel's buffer-full is low captures the data inputs into the latch and sets buffer-full within four clocks.
- R3: A strobe that falls while buffer-full is high is ignored, and the latch keeps the unread byte.
- R4: A rising strobe edge sets the interrupt request when buffer-full is high and the channel's enable bit is 1. With the enable bit at 0, the request stays low.
- R5: A command (`wr_en`=1, `cs_n`=0) with bit 7 = 0 carries a bit index in bits 3:1 and a value in bit 0. Index 4 writes channel A's enable bit, and index 2 writes channel B's enable bit.
- R6: Index 6 writes `gp_out[0]` and index 7 writes `gp_out[1]`. The handshake logic never changes them.
- R7: A command word with bit 7 = 1, or with any other index, changes no enable bit and no `gp_out` bit.
- R8: A read is `cs_n`=0 and `rd_n`=0, with `chan_sel` 0 for A and 1 for B. At the read start, the interrupt request drops. While the read lasts, `rd_data` shows the selected latch and buffer-full stays high. Buffer-full clears at the read end.
- R9: Clearing a channel's enable bit drops its pending interrupt request within two clocks and leaves buffer-full unchanged.
- R10: The two channels are independent. A handshake on one leaves the other's buffer-full and interrupt request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_data_in | input | 8 | Channel A data from the device |
| a_stb_n | input | 1 | Channel A strobe, active low |
| b_data_in | input | 8 | Channel B data from the device |
| b_stb_n | input | 1 | Channel B strobe, active low |
| a_full | output | 1 | Channel A buffer full |
| a_irq | output | 1 | Channel A interrupt request |
| b_full | output | 1 | Channel B buffer full |
| b_irq | output | 1 | Channel B interrupt request |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| chan_sel | input | 1 | Read channel: 0 = A, 1 = B |
| wr_en | input | 1 | One-clock command write strobe |
| wr_data | input | 8 | Command word |
| rd_data | output | 8 | Registered read data, 0 when no read is active |
| gp_out | output | 2 | General-purpose output lines |

## Verification
The assertions take for granted that devices keep their data lines stable from before the strobe falls until after it rises. They also take for granted that host bus inputs change only away from the rising clock edge. The bench drives all inputs on the falling clock edge and holds each strobe low and high for several clocks, so every edge gets through the synchronizer. The bench strobes into a full buffer on purpose to exercise R3, but it never starts a read of one channel while a read of the other is in progress.

// File: rtl/sip_pkg.sv
package sip_pkg;
  localparam int NUM_CH   = 2;
  localparam int IDX_W    = 3;
  localparam int IDX_EN_A = 4;
  localparam int IDX_EN_B = 2;
  localparam int IDX_GP0  = 6;
  localparam int IDX_GP1  = 7;

  // A command word is a bit set/reset only when its top bit is zero
  function automatic logic is_bit_cmd(input logic [7:0] w);
    return ~w[7];
  endfunction

  function automatic logic [IDX_W-1:0] cmd_index(input logic [7:0] w);
    return w[3:1];
  endfunction

  function automatic logic cmd_value(input logic [7:0] w);
    return w[0];
  endfunction

  // Control index that owns the enable bit of a channel
  function automatic logic [IDX_W-1:0] enable_index(input int ch);
    return (ch == 0) ? IDX_W'(IDX_EN_A) : IDX_W'(IDX_EN_B);
  endfunction
endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];
  assign rise = ~prev & chain[STAGES-1];

  p_edges_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall && rise));
endmodule

// File: rtl/sip_channel.sv
module sip_channel #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic              stb_fall,
  input  logic              stb_rise,
  input  logic              inte,
  input  logic              rd_active,
  input  logic              rd_start,
  input  logic              rd_end,
  output logic [DATA_W-1:0] latch_q,
  output logic              full_q,
  output logic              irq_q
);
  logic capture;
  logic irq_set;
  logic irq_clr;

  assign capture = stb_fall & ~full_q;
  assign irq_set = stb_rise & full_q & inte & ~rd_active;
  assign irq_clr = rd_start | rd_end | ~inte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (capture) latch_q <= data_in;
      if (rd_end) full_q <= 1'b0;
      else if (capture) full_q <= 1'b1;
      if (irq_clr) irq_q <= 1'b0;
      else if (irq_set) irq_q <= 1'b1;
    end
  end

  p_full_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && !full_q && !rd_end) |=> full_q);
  p_hold_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(latch_q));
  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(stb_rise) && $past(inte)));
  p_irq_implies_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> full_q);
  p_irq_drops_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !irq_q);
  p_irq_drops_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inte |=> !irq_q);
endmodule

// File: rtl/sip_host.sv
module sip_host
  import sip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              chan_sel,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [DATA_W-1:0] latch_bus [NUM_CH],
  output logic [NUM_CH-1:0] inte,
  output logic [1:0]        gp,
  output logic [NUM_CH-1:0] rd_active,
  output logic [NUM_CH-1:0] rd_start,
  output logic [NUM_CH-1:0] rd_end,
  output logic [DATA_W-1:0] rd_data
);
  logic [NUM_CH-1:0] rd_prev;
  logic              cmd_ok;
  logic [IDX_W-1:0]  idx;

  assign cmd_ok = wr_en & ~cs_n & is_bit_cmd(wr_data);
  assign idx    = cmd_index(wr_data);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rd_active[c] = ~cs_n & ~rd_n & (chan_sel == c[0]);
    assign rd_start[c]  = rd_active[c] & ~rd_prev[c];
    assign rd_end[c]    = ~rd_active[c] & rd_prev[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_prev[c] <= 1'b0;
        inte[c]    <= 1'b0;
      end else begin
        rd_prev[c] <= rd_active[c];
        if (cmd_ok && idx == enable_index(c)) inte[c] <= cmd_value(wr_data);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp      <= '0;
      rd_data <= '0;
    end else begin
      if (cmd_ok && idx == IDX_W'(IDX_GP0)) gp[0] <= cmd_value(wr_data);
      if (cmd_ok && idx == IDX_W'(IDX_GP1)) gp[1] <= cmd_value(wr_data);
      rd_data <= (~cs_n & ~rd_n) ? latch_bus[chan_sel] : '0;
    end
  end

  p_enable_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !cs_n) |=> ($stable(inte) && $stable(gp)));
  p_mode_word_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7]) |=> ($stable(inte) && $stable(gp)));
  p_one_read_at_a_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_active));
endmodule

// File: rtl/strobe_in_port.sv
module strobe_in_port
  import sip_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_data_in,
  input  logic              a_stb_n,
  input  logic [DATA_W-1:0] b_data_in,
  input  logic              b_stb_n,
  output logic              a_full,
  output logic              a_irq,
  output logic              b_full,
  output logic              b_irq,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              chan_sel,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        gp_out
);
  logic [DATA_W-1:0] data_arr  [NUM_CH];
  logic [DATA_W-1:0] latch_arr [NUM_CH];
  logic [NUM_CH-1:0] stb_arr, fall_w, rise_w, full_w, irq_w;
  logic [NUM_CH-1:0] inte_w, rd_act_w, rd_start_w, rd_end_w;

  assign data_arr[0] = a_data_in;
  assign data_arr[1] = b_data_in;
  assign stb_arr     = {b_stb_n, a_stb_n};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sip_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(stb_arr[c]),
      .fall(fall_w[c]), .rise(rise_w[c])
    );
    sip_channel #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .data_in(data_arr[c]),
      .stb_fall(fall_w[c]), .stb_rise(rise_w[c]), .inte(inte_w[c]),
      .rd_active(rd_act_w[c]), .rd_start(rd_start_w[c]), .rd_end(rd_end_w[c]),
      .latch_q(latch_arr[c]), .full_q(full_w[c]), .irq_q(irq_w[c])
    );
  end

  sip_host #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .chan_sel(chan_sel),
    .wr_en(wr_en), .wr_data(wr_data), .latch_bus(latch_arr),
    .inte(inte_w), .gp(gp_out), .rd_active(rd_act_w),
    .rd_start(rd_start_w), .rd_end(rd_end_w), .rd_data(rd_data)
  );

  assign a_full = full_w[0];
  assign a_irq  = irq_w[0];
  assign b_full = full_w[1];
  assign b_irq  = irq_w[1];

  p_channels_independent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_w[1] && !rd_end_w[1]) |=> $stable(latch_arr[1]));
endmodule

// File: tb/strobe_in_port_bench.sv
module strobe_in_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] a_data_in = '0, b_data_in = '0, wr_data = '0;
  logic a_stb_n = 1'b1, b_stb_n = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, chan_sel = 1'b0, wr_en = 1'b0;
  logic a_full, a_irq, b_full, b_irq;
  logic [7:0] rd_data;
  logic [1:0] gp_out;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_in_port u_strobe_in_port (
    .clk(clk), .rst_n(rst_n), .a_data_in(a_data_in), .a_stb_n(a_stb_n),
    .b_data_in(b_data_in), .b_stb_n(b_stb_n), .a_full(a_full), .a_irq(a_irq),
    .b_full(b_full), .b_irq(b_irq), .cs_n(cs_n), .rd_n(rd_n), .chan_sel(chan_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .gp_out(gp_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic full_of(input int ch);
    return ch == 0 ? a_full : b_full;
  endfunction
  function automatic logic irq_of(input int ch);
    return ch == 0 ? a_irq : b_irq;
  endfunction

  // Command word: bit7=0, bits3:1 index, bit0 value
  function automatic logic [7:0] cmd_word(input int idx, input logic val);
    return {4'b0000, idx[2:0], val};
  endfunction

  task automatic send_cmd(input logic [7:0] w);
    wr_data = w; wr_en = 1'b1; cs_n = 1'b0;
    cyc(1);
    wr_en = 1'b0; cs_n = 1'b1;
    cyc(1);
  endtask

  task automatic strobe(input int ch, input logic [7:0] d);
    if (ch == 0) a_data_in = d; else b_data_in = d;
    cyc(1);
    if (ch == 0) a_stb_n = 1'b0; else b_stb_n = 1'b0;
    cyc(5);
    if (ch == 0) a_stb_n = 1'b1; else b_stb_n = 1'b1;
    cyc(5);
  endtask

  task automatic read_chan(input int ch, input logic [7:0] exp_d);
    chan_sel = ch[0]; cs_n = 1'b0; rd_n = 1'b0;
    cyc(2);
    check("R8 irq low during read", {31'd0, irq_of(ch)}, 0);
    check("R8 full held during read", {31'd0, full_of(ch)}, 1);
    check("R8 read data", {24'd0, rd_data}, {24'd0, exp_d});
    cs_n = 1'b1; rd_n = 1'b1;
    cyc(2);
    check("R8 full cleared after read", {31'd0, full_of(ch)}, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    check("R1 a_full", {31'd0, a_full}, 0);
    check("R1 b_full", {31'd0, b_full}, 0);
    check("R1 a_irq", {31'd0, a_irq}, 0);
    check("R1 b_irq", {31'd0, b_irq}, 0);
    check("R1 gp_out", {30'd0, gp_out}, 0);
    check("R1 rd_data", {24'd0, rd_data}, 0);

    // Sweep both channels over data values, enable on and off
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 10; k++) begin
        logic [7:0] v;
        logic en;
        v  = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 37 + ch * 11) ^ 8'h5A);
        en = k[0];
        send_cmd(cmd_word(ch == 0 ? 4 : 2, en));   // R5
        strobe(ch, v);
        check("R2 full set", {31'd0, full_of(ch)}, 1);
        check("R10 other full", {31'd0, full_of(1 - ch)}, 0);
        check("R10 other irq", {31'd0, irq_of(1 - ch)}, 0);
        check("R4/R5 irq follows enable", {31'd0, irq_of(ch)}, {31'd0, en});
        strobe(ch, ~v);                            // R3 ignored strobe
        check("R3 full kept", {31'd0, full_of(ch)}, 1);
        read_chan(ch, v);
      end
    end

    // R9: clearing enable drops pending request
    send_cmd(cmd_word(4, 1'b1));
    strobe(0, 8'h3C);
    check("R9 irq before clear", {31'd0, a_irq}, 1);
    send_cmd(cmd_word(4, 1'b0));
    check("R9 irq after clear", {31'd0, a_irq}, 0);
    check("R9 full unchanged", {31'd0, a_full}, 1);
    read_chan(0, 8'h3C);

    // R6: general-purpose outputs
    send_cmd(cmd_word(6, 1'b1));
    check("R6 gp after idx6 set", {30'd0, gp_out}, 1);
    send_cmd(cmd_word(7, 1'b1));
    check("R6 gp after idx7 set", {30'd0, gp_out}, 3);
    send_cmd(cmd_word(6, 1'b0));
    check("R6 gp after idx6 clear", {30'd0, gp_out}, 2);
    strobe(1, 8'hC3);
    read_chan(1, 8'hC3);
    check("R6 gp untouched by handshake", {30'd0, gp_out}, 2);

    // R7: mode word and unused index change nothing
    send_cmd(8'h80 | cmd_word(4, 1'b1));
    send_cmd(8'h80 | cmd_word(6, 1'b1));
    send_cmd(cmd_word(5, 1'b1));
    check("R7 gp unchanged", {30'd0, gp_out}, 2);
    strobe(0, 8'h99);
    check("R7 enable A unchanged", {31'd0, a_irq}, 0);
    read_chan(0, 8'h99);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule